// File: doc/BRIEF.md
# Tunneling I/O frame builder

This block assembles a fixed sixteen-byte I/O frame and sends it, one byte per clock, to a byte-wide serializer. Frames follow each other without gaps once reset is released. Each frame begins with a comma control character, flagged on a side-band k output. A frame subtype byte and a rolling frame counter come next. After them the frame carries sixteen low-latency GPIO bits and a sixteen-bit window of a larger normal-latency GPIO vector. It also carries sampled data and flow-control bits for two UARTs, event codes for six I2C/SMBus channels, four zero bytes and a closing CRC8.

The frame counter selects which slice of the normal-latency vector a frame carries. A receiver reads the counter byte and so knows which GPIO indices the two normal-latency bytes hold. All payload inputs are captured once per frame, at the moment the comma byte is launched. The rest of the frame is therefore self-consistent even if the inputs move while it is being sent. Channel groups can be disabled by parameter. Their bytes keep their positions and are sent as zero.

Top module: `tio_frame_builder`

## Requirements
- R1: While rst is high, out_valid, out_byte, out_k and out_sof are all zero.
- R2: From the first clock after reset is released, out_valid is high on every cycle. Bytes come in back-to-back frames of 16, and out_sof is high exactly on byte 0 of each frame.
- R3: Byte 0 is 8'hBC with out_k high; out_k is low on every other byte.
- R4: Byte 1 equals the SUBTYPE parameter (default 8'h01).
- R5: Byte 2 is the frame counter: 0 in the first frame after reset, then +1 per frame, wrapping from NL_SLICES-1 to 0.
- R6: Byte 3 holds ll_gpio[7:0] and byte 4 holds ll_gpio[15:8], bit n of the byte being GPIO base+n.
- R7: With c the counter value in byte 2, byte 5 holds nl_gpio[16c+7:16c] and byte 6 holds nl_gpio[16c+15:16c+8], lowest index in bit 0.
- R8: Byte 7 bits 2:0 are uart_smp[2:0] and bit 3 is uart_fc[0] (UART0); bits 6:4 are uart_smp[5:3] and bit 7 is uart_fc[1] (UART1).
- R9: Bytes 8, 9 and 10 carry I2C channel pairs (0,1), (2,3) and (4,5). Channel k's 4-bit code is i2c_evt[4k+3:4k], and the even channel goes in bits 3:0 with the odd channel in bits 7:4.
- R10: Bytes 11 to 14 are zero.
- R11: Byte 15 is a CRC8 over bytes 1 to 14 in order, polynomial x^8+x^2+x+1 (0x07), initial value 0, data taken MSB first, no final XOR.
- R12: All payload bytes of a frame reflect the input values at the clock edge that launches that frame's comma byte; input changes during the frame do not affect it.
- R13: A channel disabled by EN_LL, EN_NL, EN_UART[u] or EN_I2C[k] is sent as zero in its own field, and every other byte keeps its position and content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| ll_gpio | input | 16 | Low-latency GPIO vector |
| nl_gpio | input | 16*NL_SLICES | Normal-latency GPIO vector, 16 bits carried per frame |
| uart_smp | input | 6 | Three data-line samples per UART, UART0 in [2:0], UART1 in [5:3] |
| uart_fc | input | 2 | Flow-control line per UART |
| i2c_evt | input | 24 | 4-bit event code per I2C/SMBus channel, channel k at [4k+3:4k] |
| out_valid | output | 1 | Byte stream valid |
| out_byte | output | 8 | Frame byte |
| out_k | output | 1 | Byte is a control character |
| out_sof | output | 1 | Byte is the first of a frame |

## Verification
A slip in the byte-position state shows at once: the comma, k flag and start flag leave their 16-cycle cadence within the same frame. A corrupted frame-counter state shows at byte 2 and in the normal-latency window of that frame. A bad CRC accumulator stays hidden until byte 15, and a stale or torn input snapshot shows as a payload byte that does not match the inputs present at the comma edge. The reference model follows every byte of a full-function instance and of one with mixed disabled channels. It also runs through a mid-stream reset, so counter restart and wrap at two different slice counts are covered.

// File: rtl/tio_pkg.sv
package tio_pkg;

    localparam int          FRAME_BYTES = 16;
    localparam int          POS_W       = 4;
    localparam logic [7:0]  COMMA_K     = 8'hBC;
    localparam logic [7:0]  CRC_POLY    = 8'h07;
    localparam int          LL_W        = 16;
    localparam int          NL_WIN_W    = 16;
    localparam int          UART_N      = 2;
    localparam int          UART_SMP    = 3;
    localparam int          I2C_CH      = 6;
    localparam int          EVT_W       = 4;

    // Byte positions inside a frame; the order is what the receiver decodes.
    typedef enum logic [POS_W-1:0] {
        P_COMMA  = 4'd0,
        P_SUBTYP = 4'd1,
        P_FCNT   = 4'd2,
        P_LL_LO  = 4'd3,
        P_LL_HI  = 4'd4,
        P_NL_LO  = 4'd5,
        P_NL_HI  = 4'd6,
        P_UART   = 4'd7,
        P_I2C_A  = 4'd8,
        P_I2C_B  = 4'd9,
        P_I2C_C  = 4'd10,
        P_RSV0   = 4'd11,
        P_RSV1   = 4'd12,
        P_RSV2   = 4'd13,
        P_RSV3   = 4'd14,
        P_CRC    = 4'd15
    } pos_e;

    // Payload captured once per frame, already masked by the channel enables.
    typedef struct packed {
        logic [LL_W-1:0]              ll;
        logic [NL_WIN_W-1:0]          nl_win;
        logic [UART_N*UART_SMP-1:0]   uart_smp;
        logic [UART_N-1:0]            uart_fc;
        logic [I2C_CH*EVT_W-1:0]      i2c;
    } snap_t;

    function automatic logic [7:0] crc8_next(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int i = 0; i < 8; i++) begin
            r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/tio_seq.sv
module tio_seq
    import tio_pkg::*;
#(
    parameter  int NL_SLICES = 4,
    localparam int FC_W      = (NL_SLICES > 1) ? $clog2(NL_SLICES) : 1
) (
    input  logic            clk,
    input  logic            rst,
    output pos_e            pos,
    output logic [FC_W-1:0] fcnt
);

    localparam logic [FC_W-1:0] FC_LAST = FC_W'(NL_SLICES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos  <= P_COMMA;
            fcnt <= '0;
        end else begin
            pos <= pos_e'(pos + 1'b1);
            if (pos == P_CRC) begin
                fcnt <= (fcnt == FC_LAST) ? '0 : fcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tio_crc8.sv
module tio_crc8
    import tio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] crc
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc <= 8'h00;
        end else if (en) begin
            crc <= crc8_next(crc, din);
        end
    end

endmodule

// File: rtl/tio_field_mux.sv
module tio_field_mux
    import tio_pkg::*;
#(
    parameter logic [7:0] SUBTYPE = 8'h01,
    parameter int         FC_W    = 2
) (
    input  pos_e            pos,
    input  logic [FC_W-1:0] fcnt,
    input  snap_t           snap,
    input  logic [7:0]      crc,
    output logic [7:0]      byte_o,
    output logic            k_o
);

    always_comb begin
        k_o = (pos == P_COMMA);
        unique case (pos)
            P_COMMA:  byte_o = COMMA_K;
            P_SUBTYP: byte_o = SUBTYPE;
            P_FCNT:   byte_o = 8'(fcnt);
            P_LL_LO:  byte_o = snap.ll[7:0];
            P_LL_HI:  byte_o = snap.ll[15:8];
            P_NL_LO:  byte_o = snap.nl_win[7:0];
            P_NL_HI:  byte_o = snap.nl_win[15:8];
            P_UART:   byte_o = {snap.uart_fc[1], snap.uart_smp[5:3],
                                snap.uart_fc[0], snap.uart_smp[2:0]};
            P_I2C_A:  byte_o = snap.i2c[7:0];
            P_I2C_B:  byte_o = snap.i2c[15:8];
            P_I2C_C:  byte_o = snap.i2c[23:16];
            P_CRC:    byte_o = crc;
            default:  byte_o = 8'h00;
        endcase
    end

endmodule

// File: rtl/tio_frame_builder.sv
module tio_frame_builder
    import tio_pkg::*;
#(
    parameter int         NL_SLICES = 4,
    parameter logic [7:0] SUBTYPE   = 8'h01,
    parameter bit         EN_LL     = 1'b1,
    parameter bit         EN_NL     = 1'b1,
    parameter logic [1:0] EN_UART   = 2'b11,
    parameter logic [5:0] EN_I2C    = 6'b111111
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [15:0]                   ll_gpio,
    input  logic [NL_SLICES*16-1:0]       nl_gpio,
    input  logic [5:0]                    uart_smp,
    input  logic [1:0]                    uart_fc,
    input  logic [23:0]                   i2c_evt,
    output logic                          out_valid,
    output logic [7:0]                    out_byte,
    output logic                          out_k,
    output logic                          out_sof
);

    localparam int FC_W = (NL_SLICES > 1) ? $clog2(NL_SLICES) : 1;

    pos_e                       pos;
    logic [FC_W-1:0]            fcnt;
    logic [7:0]                 crc;
    logic [7:0]                 mux_byte;
    logic                       mux_k;
    snap_t                      snap_d, snap_q;
    logic [UART_N*UART_SMP-1:0] uart_m;
    logic [UART_N-1:0]          fc_m;
    logic [I2C_CH*EVT_W-1:0]    i2c_m;
    logic [NL_WIN_W-1:0]        nl_sel;

    tio_seq #(.NL_SLICES(NL_SLICES)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .pos  (pos),
        .fcnt (fcnt)
    );

    // Channel masking: each disabled group is zeroed before capture.
    for (genvar u = 0; u < UART_N; u++) begin : g_uart
        assign uart_m[u*UART_SMP +: UART_SMP] = EN_UART[u] ? uart_smp[u*UART_SMP +: UART_SMP] : '0;
        assign fc_m[u]                        = EN_UART[u] ? uart_fc[u] : 1'b0;
    end

    for (genvar k = 0; k < I2C_CH; k++) begin : g_i2c
        assign i2c_m[k*EVT_W +: EVT_W] = EN_I2C[k] ? i2c_evt[k*EVT_W +: EVT_W] : '0;
    end

    assign nl_sel = nl_gpio[int'(fcnt)*NL_WIN_W +: NL_WIN_W];

    assign snap_d = '{
        ll:       EN_LL ? ll_gpio : '0,
        nl_win:   EN_NL ? nl_sel  : '0,
        uart_smp: uart_m,
        uart_fc:  fc_m,
        i2c:      i2c_m
    };

    // Capture on the edge that launches the comma, so a frame is coherent.
    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
        end else if (pos == P_COMMA) begin
            snap_q <= snap_d;
        end
    end

    tio_field_mux #(.SUBTYPE(SUBTYPE), .FC_W(FC_W)) u_mux (
        .pos    (pos),
        .fcnt   (fcnt),
        .snap   (snap_q),
        .crc    (crc),
        .byte_o (mux_byte),
        .k_o    (mux_k)
    );

    tio_crc8 u_crc (
        .clk   (clk),
        .rst   (rst),
        .clear (pos == P_COMMA),
        .en    ((pos != P_COMMA) && (pos != P_CRC)),
        .din   (mux_byte),
        .crc   (crc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_byte  <= 8'h00;
            out_k     <= 1'b0;
            out_sof   <= 1'b0;
        end else begin
            out_valid <= 1'b1;
            out_byte  <= mux_byte;
            out_k     <= mux_k;
            out_sof   <= (pos == P_COMMA);
        end
    end

endmodule

// File: rtl/tio_frame_chk.sv
module tio_frame_chk #(
    parameter int NL_SLICES = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       out_valid,
    input logic [7:0] out_byte,
    input logic       out_k,
    input logic       out_sof
);

    logic [3:0] cnt;
    logic [7:0] exp_fc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= 4'd0;
            exp_fc <= 8'd0;
        end else if (out_valid) begin
            cnt <= cnt + 4'd1;
            if (cnt == 4'd2) begin
                exp_fc <= (exp_fc == 8'(NL_SLICES - 1)) ? 8'd0 : exp_fc + 8'd1;
            end
        end
    end

    p_valid_hold_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid);

    p_sof_cadence_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sof == (cnt == 4'd0)));

    p_comma_k_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sof) |-> (out_byte == 8'hBC && out_k));

    p_k_only_comma_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_sof) |-> !out_k);

    p_fcnt_step_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && cnt == 4'd2) |-> (out_byte == exp_fc));

    p_rsv_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && cnt >= 4'd11 && cnt <= 4'd14) |-> (out_byte == 8'h00));

endmodule

bind tio_frame_builder tio_frame_chk #(.NL_SLICES(NL_SLICES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .out_k     (out_k),
    .out_sof   (out_sof)
);

// File: tb/tb_tio_frame_builder.sv
module tb_tio_frame_builder;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] ll;
    logic [63:0] nl;
    logic [5:0]  us;
    logic [1:0]  uf;
    logic [23:0] ie;

    logic       v_a, k_a, s_a, v_b, k_b, s_b;
    logic [7:0] b_a, b_b;

    int total = 0;
    int bad   = 0;
    bit started = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tio_frame_builder dut (
        .clk(clk), .rst(rst), .ll_gpio(ll), .nl_gpio(nl), .uart_smp(us),
        .uart_fc(uf), .i2c_evt(ie), .out_valid(v_a), .out_byte(b_a),
        .out_k(k_a), .out_sof(s_a)
    );

    // Partial build for R13: LL off, UART0 off, I2C channels 0,2,3,5 off, 3 slices.
    tio_frame_builder #(
        .NL_SLICES(3), .SUBTYPE(8'h5A), .EN_LL(1'b0), .EN_NL(1'b1),
        .EN_UART(2'b10), .EN_I2C(6'b010010)
    ) dut_part (
        .clk(clk), .rst(rst), .ll_gpio(ll), .nl_gpio(nl[47:0]), .uart_smp(us),
        .uart_fc(uf), .i2c_evt(ie), .out_valid(v_b), .out_byte(b_b),
        .out_k(k_b), .out_sof(s_b)
    );

    typedef logic [7:0] frm_t [16];

    function automatic logic [7:0] ref_crc(input frm_t f);
        logic [7:0] c;
        logic fb;
        c = 8'h00;
        for (int n = 1; n <= 14; n++) begin
            for (int i = 7; i >= 0; i--) begin
                fb = c[7] ^ f[n][i];
                c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
            end
        end
        return c;
    endfunction

    function automatic frm_t make_frame(input int fc, input bit enll, input bit ennl,
                                        input logic [1:0] enu, input logic [5:0] eni,
                                        input logic [7:0] sub);
        frm_t f;
        for (int n = 0; n < 16; n++) f[n] = 8'h00;
        f[0] = 8'hBC;
        f[1] = sub;
        f[2] = fc[7:0];
        if (enll) begin
            f[3] = ll[7:0];
            f[4] = ll[15:8];
        end
        if (ennl) begin
            for (int j = 0; j < 16; j++) f[5 + j/8][j%8] = nl[fc*16 + j];
        end
        f[7][3:0] = enu[0] ? {uf[0], us[2:0]} : 4'h0;
        f[7][7:4] = enu[1] ? {uf[1], us[5:3]} : 4'h0;
        for (int ch = 0; ch < 6; ch++) begin
            f[8 + ch/2][(ch%2)*4 +: 4] = eni[ch] ? ie[ch*4 +: 4] : 4'h0;
        end
        f[15] = ref_crc(f);
        return f;
    endfunction

    function automatic string req_of(input int p);
        case (p)
            0:       return "R3";
            1:       return "R4";
            2:       return "R5";
            3, 4:    return "R6";
            5, 6:    return "R7";
            7:       return "R8";
            8, 9, 10: return "R9";
            15:      return "R11";
            default: return "R10";
        endcase
    endfunction

    // Reference model: snapshot of inputs at the comma edge (R12), queued per byte.
    int qa[$];
    int qb[$];
    int pa, fa, pb, fb;
    frm_t fr;

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            qa.delete(); qb.delete();
            pa = 0; fa = 0; pb = 0; fb = 0;
        end else begin
            if (pa == 0) begin
                fr = make_frame(fa, 1'b1, 1'b1, 2'b11, 6'b111111, 8'h01);
                for (int n = 0; n < 16; n++) qa.push_back(n*256 + int'(fr[n]));
                fa = (fa + 1) % 4;
            end
            pa = (pa + 1) % 16;
            if (pb == 0) begin
                fr = make_frame(fb, 1'b0, 1'b1, 2'b10, 6'b010010, 8'h5A);
                for (int n = 0; n < 16; n++) qb.push_back(n*256 + int'(fr[n]));
                fb = (fb + 1) % 3;
            end
            pb = (pb + 1) % 16;
        end
    end

    task automatic chk_idle(input logic v, input logic [7:0] b, input logic k, input logic s,
                            input string tag);
        total++;
        if (v !== 1'b0 || b !== 8'h00 || k !== 1'b0 || s !== 1'b0) begin
            bad++;
            $display("FAIL R1 %s: valid=%b byte=%h k=%b sof=%b expected all zero", tag, v, b, k, s);
        end
    endtask

    task automatic chk_byte(input int it, input logic v, input logic [7:0] b, input logic k,
                            input logic s, input string tag);
        int p;
        logic [7:0] eb;
        p  = it / 256;
        eb = 8'(it % 256);
        total++;
        if (v !== 1'b1 || s !== (p == 0)) begin
            bad++;
            $display("FAIL R2 %s pos %0d: valid=%b sof=%b expected valid=1 sof=%b", tag, p, v, s, p == 0);
        end
        total++;
        if (k !== (p == 0)) begin
            bad++;
            $display("FAIL R3 %s pos %0d: k=%b expected %b", tag, p, k, p == 0);
        end
        total++;
        if (b !== eb) begin
            bad++;
            $display("FAIL %s %s pos %0d: byte=%h expected %h", req_of(p), tag, p, b, eb);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            if (qa.size() == 0) chk_idle(v_a, b_a, k_a, s_a, "full");
            else chk_byte(qa.pop_front(), v_a, b_a, k_a, s_a, "full");
            if (qb.size() == 0) chk_idle(v_b, b_b, k_b, s_b, "R13-part");
            else chk_byte(qb.pop_front(), v_b, b_b, k_b, s_b, "R13-part");
        end
    end

    task automatic rand_inputs();
        ll = 16'($urandom);
        nl = {$urandom, $urandom};
        us = 6'($urandom);
        uf = 2'($urandom);
        ie = 24'($urandom);
    endtask

    initial begin
        rst = 1'b1;
        ll = '0; nl = '0; us = '0; uf = '0; ie = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // All-zero payload: CRC of a quiet frame, counter wrap R5.
        repeat (80) @(negedge clk);
        // All-ones payload: every field full, masks of R13 visible.
        ll = '1; nl = '1; us = '1; uf = '1; ie = '1;
        repeat (80) @(negedge clk);
        // Inputs change every cycle: frames must hold the comma-edge snapshot (R12).
        repeat (640) begin
            @(negedge clk);
            rand_inputs();
        end
        // Walking one through the NL vector and others: slice placement R7, R6.
        for (int i = 0; i < 64; i++) begin
            nl = 64'd1 << i;
            ll = 16'd1 << (i % 16);
            us = 6'd1 << (i % 6);
            uf = 2'd1 << (i % 2);
            ie = 24'd1 << (i % 24);
            repeat (8) @(negedge clk);
        end
        // Mid-stream reset: idle outputs, then counter restarts at 0 (R1, R5).
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (320) begin
            @(negedge clk);
            if ($urandom % 4 == 0) rand_inputs();
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule